// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the two data lines of a low-speed USB link, sampled by a clock running at a fixed multiple of the 1.5 Mbit/s bit rate, and turns each incoming packet into bytes. It looks for the start-of-packet sync field. The line is idle at J (D+ low, D- high), and K is D+ high with D- low. The block aligns its bit-centre sampling to the line edges, and recognises the end of sync from two K bits in a row. After that it decodes NRZI, drops stuffed bits and assembles bytes least significant bit first.

Each finished byte is written through a write strobe, address and data bus into a receive buffer of `BUF_BYTES` entries. The first byte goes to address 0. When both lines are low (SE0) at a bit centre, the packet ends. One cycle-wide pulse then reports the outcome: `packet_done` with the byte count, or `packet_error` when the packet must be thrown away. CRC checking, PID meaning and the analog transceiver are not part of this block.

The inputs are expected to be synchronised to `clk` already. Every line transition resets the bit-phase counter, so a sender whose clock drifts by a few percent is still sampled near the bit centre.

Top module: `lowspeed_rx`

## Requirements
- R1: After a synchronous active-low reset, `wr_en`, `packet_done`, `packet_error` and `byte_count` are 0, and the receiver waits for a J-to-K edge on the idle line.
- R2: Data decoding starts only after the sync field's two final K bits have been seen at two consecutive bit centres. The sync field is K J K J K J K K, one bit period per symbol.
- R3: A data bit is 1 when the line state at its centre equals the previous bit's state, and 0 when it differs. Bits fill each byte from bit 0 to bit 7. Byte n of a packet is written with `wr_en` high, `wr_addr` = n and `wr_data` = the byte.
- R4: After six consecutive 1s, the next bit is discarded. The final K of sync counts as the first of these 1s. The discarded bit's line state becomes the NRZI reference, and the run count restarts at zero. A 0 also restarts the run count.
- R5: If the bit that should be stuffed shows no line change, the packet ends with `packet_error` and no `packet_done`.
- R6: SE0 at a bit centre ends the packet. If the packet is clean, `packet_done` pulses and `byte_count` holds the number of bytes written. A packet with no data bytes reports a count of 0.
- R7: A packet whose bit count after unstuffing is not a multiple of 8 ends with `packet_error`.
- R8: Bytes beyond `BUF_BYTES` are not written. Such a packet ends with `packet_error` and no `packet_done`. A packet of exactly `BUF_BYTES` bytes completes normally.
- R9: During the sync search, a line level held for `SYNC_TIMEOUT` samples returns the receiver to idle. This produces no write and no pulse, and a following packet is received normally.
- R10: The bit-centre counter restarts on every line transition. Packets whose bit periods alternate between `OVERSAMPLE` and `OVERSAMPLE`+1 samples decode correctly.
- R11: `packet_done` and `packet_error` are single-cycle pulses. They are never high together, and each packet end produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, `OVERSAMPLE` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| dp | input | 1 | D+ line level, already synchronised |
| dm | input | 1 | D- line level, already synchronised |
| wr_en | output | 1 | Buffer write strobe, one cycle per byte |
| wr_addr | output | $clog2(BUF_BYTES) | Buffer address of the byte being written |
| wr_data | output | 8 | Received byte |
| byte_count | output | $clog2(BUF_BYTES+1) | Byte count of the last clean packet, held |
| packet_done | output | 1 | Pulse: packet ended cleanly |
| packet_error | output | 1 | Pulse: packet ended with overflow, stuff error or partial byte |

## Verification
The bench builds the receiver with `OVERSAMPLE` = 8, `SYNC_TIMEOUT` = 24 and `BUF_BYTES` = 4. The small buffer means a five-byte packet already overflows, so both the exact-fit case and the discard case fit in short packets. With 24 samples, the timeout fires after three idle bit periods of J, well before a real sync field would finish. The 8x rate lets the bench stretch alternate bits to 9 samples and check that re-centring on edges keeps every seven-bit run intact.

// File: rtl/lsrx_pkg.sv
// Shared types for the low-speed receiver.
// Assumes: line pins are already synchronised to the sample clock.
package lsrx_pkg;

    // Decoded line symbol; the 2'd3 code is never produced.
    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2
    } sym_t;

    // Receiver framing state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } rx_state_t;

    // Consecutive ones that force a stuffed bit.
    localparam int STUFF_RUN = 6;

    // Map the two pins to a symbol: both low is SE0, D+ high is K, else J.
    function automatic sym_t classify(input logic p, input logic m);
        if (!p && !m) return SYM_SE0;
        if (p)        return SYM_K;
        return SYM_J;
    endfunction

endpackage

// File: rtl/lsrx_timing.sv
// Bit-timing recovery and packet framing.
// Registers the line symbol, keeps a bit-phase counter restarted at every
// transition, searches the sync field for two K centres in a row, then
// emits one strobe per bit centre until SE0 is seen at a centre.
// Assumes OVERSAMPLE >= 4 and SYNC_TIMEOUT > 2 * OVERSAMPLE.
module lsrx_timing
    import lsrx_pkg::*;
#(
    parameter int OVERSAMPLE   = 8,
    parameter int SYNC_TIMEOUT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dp,
    input  logic dm,
    output sym_t sym,
    output logic lock,
    output logic data_stb,
    output logic eop
);
    localparam int PH_W   = $clog2(OVERSAMPLE);
    localparam int TMO_W  = $clog2(SYNC_TIMEOUT + 1);
    localparam int CENTRE = OVERSAMPLE / 2;

    sym_t             sym_q, sym_prev;
    logic [PH_W-1:0]  ph_q, ph_cur;
    logic [TMO_W-1:0] tmo_q, tmo_cur;
    rx_state_t        state_q, state_d;
    logic             kseen_q, kseen_d;
    logic             line_edge, at_centre, sync_abort;

    // Register the line symbol and its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q    <= SYM_J;
            sym_prev <= SYM_J;
        end else begin
            sym_q    <= classify(dp, dm);
            sym_prev <= sym_q;
        end
    end

    assign line_edge = (sym_q != sym_prev);
    assign ph_cur    = line_edge ? '0 : ph_q;
    assign tmo_cur   = line_edge ? '0 : tmo_q;
    assign at_centre = (ph_cur == PH_W'(CENTRE));

    // Bit-phase counter, restarted by each transition.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (ph_cur == PH_W'(OVERSAMPLE - 1))
            ph_q <= '0;
        else
            ph_q <= ph_cur + 1'b1;
    end

    // Samples since the last transition, used only during sync search.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_SYNC)
            tmo_q <= '0;
        else
            tmo_q <= tmo_cur + 1'b1;
    end

    assign sync_abort = (state_q == ST_SYNC) &&
                        (sym_q == SYM_SE0 || tmo_cur == TMO_W'(SYNC_TIMEOUT - 1));
    assign lock       = (state_q == ST_SYNC) && !sync_abort && at_centre &&
                        (sym_q == SYM_K) && kseen_q;
    assign data_stb   = (state_q == ST_DATA) && at_centre && (sym_q != SYM_SE0);
    assign eop        = (state_q == ST_DATA) && at_centre && (sym_q == SYM_SE0);
    assign sym        = sym_q;

    // Next framing state.
    always_comb begin
        state_d = state_q;
        kseen_d = kseen_q;
        case (state_q)
            ST_IDLE: begin
                kseen_d = 1'b0;
                if (line_edge && sym_q == SYM_K && sym_prev == SYM_J)
                    state_d = ST_SYNC;
            end
            ST_SYNC: begin
                if (sync_abort)
                    state_d = ST_IDLE;
                else if (lock)
                    state_d = ST_DATA;
                else if (at_centre)
                    kseen_d = (sym_q == SYM_K);
            end
            ST_DATA: begin
                kseen_d = 1'b0;
                if (eop)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Framing state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kseen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kseen_q <= kseen_d;
        end
    end

    // R2: data phase is entered only after a K centre was already seen.
    assert_data_after_two_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) != ST_DATA) |-> $past(kseen_q));

    // R9: a steady level for the whole timeout ends the sync search.
    assert_sync_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && !line_edge && tmo_q == TMO_W'(SYNC_TIMEOUT - 1))
        |=> state_q == ST_IDLE);

    // R6: an SE0 centre returns the receiver to idle.
    assert_eop_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eop |=> state_q == ST_IDLE);

endmodule

// File: rtl/lsrx_nrzi.sv
// NRZI decoder with stuffed-bit removal.
// At each bit centre compares the line with the previous reference; after
// STUFF_RUN ones the next bit is dropped and checked for a transition.
// Assumes lock arrives at the final sync K, which counts as one 1.
module lsrx_nrzi
    import lsrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic data_stb,
    input  sym_t sym,
    output logic bit_vld,
    output logic bit_val,
    output logic stuff_err
);
    localparam int ONES_W = $clog2(STUFF_RUN + 1);

    sym_t              ref_q;
    logic [ONES_W-1:0] ones_q;
    logic              stuff_slot, same;

    assign stuff_slot = (ones_q == ONES_W'(STUFF_RUN));
    assign same       = (sym == ref_q);
    assign bit_vld    = data_stb && !stuff_slot;
    assign bit_val    = same;

    // Track reference state, run of ones and stuff violations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= SYM_J;
            ones_q    <= '0;
            stuff_err <= 1'b0;
        end else if (lock) begin
            ref_q     <= SYM_K;
            ones_q    <= ONES_W'(1);
            stuff_err <= 1'b0;
        end else if (data_stb) begin
            ref_q <= sym;
            if (stuff_slot) begin
                ones_q <= '0;
                if (same)
                    stuff_err <= 1'b1;
            end else if (same) begin
                ones_q <= ones_q + 1'b1;
            end else begin
                ones_q <= '0;
            end
        end
    end

    // R4: the run counter never passes the stuff limit.
    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= ONES_W'(STUFF_RUN));

    // R4: a consumed stuff slot restarts the run.
    assert_stuff_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && stuff_slot && !lock) |=> ones_q == '0);

endmodule

// File: rtl/lsrx_pack.sv
// Byte assembly and buffer write.
// Shifts decoded bits in LSB first, writes each full byte to the next
// buffer address while room remains, and at packet end reports either the
// byte count or an error (overflow, stuff error, partial byte).
module lsrx_pack #(
    parameter int BUF_BYTES = 8,
    parameter int ADDR_W    = 3,
    parameter int CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              eop,
    input  logic              stuff_err,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  byte_count,
    output logic              packet_done,
    output logic              packet_error
);
    logic [7:0]       sh_q, sh_next;
    logic [2:0]       nbit_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q, bad;

    assign sh_next = {bit_val, sh_q[7:1]};
    assign bad     = ovf_q || stuff_err || (nbit_q != 3'd0);

    // Shift register, bit counter and buffer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            nbit_q  <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (lock) begin
                nbit_q <= '0;
                cnt_q  <= '0;
                ovf_q  <= 1'b0;
            end else if (bit_vld) begin
                sh_q   <= sh_next;
                nbit_q <= nbit_q + 1'b1;
                if (nbit_q == 3'd7) begin
                    if (cnt_q < CNT_W'(BUF_BYTES)) begin
                        wr_en   <= 1'b1;
                        wr_addr <= cnt_q[ADDR_W-1:0];
                        wr_data <= sh_next;
                        cnt_q   <= cnt_q + 1'b1;
                    end else begin
                        ovf_q <= 1'b1;
                    end
                end
            end
        end
    end

    // Packet outcome pulses and held byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            packet_done  <= 1'b0;
            packet_error <= 1'b0;
            byte_count   <= '0;
        end else begin
            packet_done  <= eop && !bad;
            packet_error <= eop && bad;
            if (eop && !bad)
                byte_count <= cnt_q;
        end
    end

    // R8: writes stay inside the buffer.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> CNT_W'(wr_addr) < CNT_W'(BUF_BYTES));

    // R8: nothing is written once the packet has overflowed.
    assert_no_write_after_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ovf_q);

    // R3: every write follows a decoded data bit.
    assert_write_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bit_vld));

    // R11: outcome pulses are exclusive and one cycle wide.
    assert_outcome_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(packet_done && packet_error));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        packet_done |=> !packet_done);
    assert_error_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        packet_error |=> !packet_error);

endmodule

// File: rtl/lowspeed_rx.sv
// Low-speed USB packet receiver top level.
// Chains bit-timing recovery, NRZI/unstuff decoding and byte packing.
// Assumes dp/dm are synchronised to clk, which runs at OVERSAMPLE x 1.5 MHz,
// and BUF_BYTES >= 2.
module lowspeed_rx #(
    parameter int OVERSAMPLE   = 8,
    parameter int SYNC_TIMEOUT = 24,
    parameter int BUF_BYTES    = 8,
    localparam int ADDR_W      = $clog2(BUF_BYTES),
    localparam int CNT_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp,
    input  logic              dm,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  byte_count,
    output logic              packet_done,
    output logic              packet_error
);
    import lsrx_pkg::*;

    sym_t sym;
    logic lock, data_stb, eop;
    logic bit_vld, bit_val, stuff_err;

    lsrx_timing #(
        .OVERSAMPLE   (OVERSAMPLE),
        .SYNC_TIMEOUT (SYNC_TIMEOUT)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .dp       (dp),
        .dm       (dm),
        .sym      (sym),
        .lock     (lock),
        .data_stb (data_stb),
        .eop      (eop)
    );

    lsrx_nrzi u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (lock),
        .data_stb  (data_stb),
        .sym       (sym),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .stuff_err (stuff_err)
    );

    lsrx_pack #(
        .BUF_BYTES (BUF_BYTES),
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W)
    ) u_pack (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock         (lock),
        .bit_vld      (bit_vld),
        .bit_val      (bit_val),
        .eop          (eop),
        .stuff_err    (stuff_err),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .byte_count   (byte_count),
        .packet_done  (packet_done),
        .packet_error (packet_error)
    );

endmodule

// File: tb/test_lowspeed_rx.sv
// Directed bench for lowspeed_rx: one task per scenario.
module test_lowspeed_rx;
    localparam int BUFN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0, dm = 1'b1;
    logic       wr_en, packet_done, packet_error;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] byte_count;

    int total = 0, bad = 0;
    int n_wr, n_done, n_err, n_both, last_cnt;
    logic [7:0] mem [0:7];
    logic [7:0] tx [0:7];
    int  cur, ones, dphase;
    bit  stuff_g, drift_g;

    always #4 clk = ~clk;

    lowspeed_rx #(.OVERSAMPLE(8), .SYNC_TIMEOUT(24), .BUF_BYTES(BUFN)) i_lowspeed_rx (
        .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_count(byte_count), .packet_done(packet_done), .packet_error(packet_error)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                n_wr++;
                mem[wr_addr] = wr_data;
            end
            if (packet_done) begin
                n_done++;
                last_cnt = int'(byte_count);
            end
            if (packet_error) n_err++;
            if (packet_done && packet_error) n_both++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_wr = 0; n_done = 0; n_err = 0; n_both = 0; last_cnt = -1;
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
    endtask

    // Drive one symbol (0 SE0, 1 J, 2 K) for one bit period.
    task automatic emit(input int s);
        int p;
        p = 8;
        if (drift_g) begin
            p = (dphase != 0) ? 9 : 8;
            dphase = 1 - dphase;
        end
        dp = (s == 2);
        dm = (s == 1);
        repeat (p) @(negedge clk);
    endtask

    // NRZI encode one bit, inserting a stuff bit when enabled.
    task automatic put_bit(input bit b);
        if (b) ones++;
        else begin
            cur = (cur == 1) ? 2 : 1;
            ones = 0;
        end
        emit(cur);
        if (stuff_g && ones == 6) begin
            cur = (cur == 1) ? 2 : 1;
            emit(cur);
            ones = 0;
        end
    endtask

    task automatic send_packet(input int nb, input int nextra, input int xval,
                               input bit stuff_en, input bit drift_en);
        stuff_g = stuff_en;
        drift_g = drift_en;
        dphase  = 1;
        emit(1); emit(1);
        emit(2); emit(1); emit(2); emit(1); emit(2); emit(1); emit(2); emit(2);
        cur = 2; ones = 1;
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 8; k++) put_bit(tx[i][k]);
        for (int k = 0; k < nextra; k++) put_bit(((xval >> k) & 1) != 0);
        emit(0); emit(0); emit(1); emit(1);
        drift_g = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_clean(input string req, input int nb);
        check(req, "done pulses", n_done, 1);
        check(req, "error pulses", n_err, 0);
        check(req, "byte_count", last_cnt, nb);
        check(req, "writes", n_wr, nb);
        for (int i = 0; i < nb; i++) check(req, "byte", int'(mem[i]), int'(tx[i]));
        check("R11", "both pulses", n_both, 0);
    endtask

    task automatic t_reset();
        check("R1", "wr_en", int'(wr_en), 0);
        check("R1", "packet_done", int'(packet_done), 0);
        check("R1", "packet_error", int'(packet_error), 0);
        check("R1", "byte_count", int'(byte_count), 0);
    endtask

    task automatic t_basic();
        clear_mon();
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h01;
        send_packet(3, 0, 0, 1, 0);
        check_clean("R2 R3 R6", 3);
    endtask

    task automatic t_stuffing();
        clear_mon();
        tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h7E;
        send_packet(3, 0, 0, 1, 0);
        check_clean("R4", 3);
    endtask

    task automatic t_stuff_error();
        clear_mon();
        tx[0] = 8'hFF; tx[1] = 8'h00;
        send_packet(2, 0, 0, 0, 0);
        check("R5", "error pulses", n_err, 1);
        check("R5", "done pulses", n_done, 0);
    endtask

    task automatic t_empty();
        clear_mon();
        send_packet(0, 0, 0, 1, 0);
        check_clean("R6", 0);
    endtask

    task automatic t_partial();
        clear_mon();
        tx[0] = 8'h5A;
        send_packet(1, 3, 5, 1, 0);
        check("R7", "error pulses", n_err, 1);
        check("R7", "done pulses", n_done, 0);
    endtask

    task automatic t_full();
        clear_mon();
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
        send_packet(4, 0, 0, 1, 0);
        check_clean("R8", 4);
    endtask

    task automatic t_overflow();
        clear_mon();
        tx[0] = 8'h81; tx[1] = 8'h42; tx[2] = 8'h24; tx[3] = 8'h18; tx[4] = 8'hC3;
        send_packet(5, 0, 0, 1, 0);
        check("R8", "writes", n_wr, BUFN);
        check("R8", "error pulses", n_err, 1);
        check("R8", "done pulses", n_done, 0);
        for (int i = 0; i < BUFN; i++) check("R8", "kept byte", int'(mem[i]), int'(tx[i]));
    endtask

    task automatic t_timeout();
        clear_mon();
        drift_g = 1'b0;
        emit(1); emit(1); emit(2); emit(1); emit(2);
        dp = 1'b0; dm = 1'b1;
        repeat (40) @(negedge clk);
        check("R9", "writes", n_wr, 0);
        check("R9", "done pulses", n_done, 0);
        check("R9", "error pulses", n_err, 0);
        tx[0] = 8'hC9; tx[1] = 8'h6E;
        send_packet(2, 0, 0, 1, 0);
        check_clean("R9", 2);
    endtask

    task automatic t_drift();
        clear_mon();
        tx[0] = 8'h00; tx[1] = 8'hFF; tx[2] = 8'h55;
        send_packet(3, 0, 0, 1, 1);
        check_clean("R10", 3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        repeat (16) @(negedge clk);
        t_basic();
        t_stuffing();
        t_stuff_error();
        t_empty();
        t_partial();
        t_full();
        t_overflow();
        t_timeout();
        t_drift();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule